// File: doc/BRIEF.md
# Overload Cut-off and Fault Sequencer

This block sits beside a power output driver and turns synchronous fault flags into three control outputs. The flags are a current peak crossing, a current still above the limit level, undervoltage, overtemperature and the driver enable line. The outputs are a gate-disable command, an active-low overload report and an active-low diagnostic flag. A current peak seen while enabled starts a current-limitation episode. The overload report appears only after a short settling time. A limitation that lasts too long becomes a timed cut-off. The cut-off is released automatically after a timed restart interval.

Undervoltage and overtemperature act on the outputs in the cycle they are flagged. Undervoltage also wipes every timer and any pending cut-off. Overtemperature leaves a running restart interval untouched, so recovery waits for whichever of the two ends last. All three durations are counted in clock cycles and set by parameters.

Top module: `drv_fault_seq`

## Requirements
- R1: After reset, with all flags low, `ovl_n_o` = 1, `diag_n_o` = 1 and `gate_off_o` = 0.
- R2: Limitation begins on the clock edge that samples `en_i` = 1 and `peak_i` = 1 with no fault. `ovl_n_o` goes to 0 only once limitation has lasted `OVL_DLY` full cycles: from the (`OVL_DLY`+1)-th cycle after the start edge's input cycle.
- R3: Limitation continues while `en_i` and `above_i` are both 1. It ends on the edge that samples either of them at 0, and `ovl_n_o` is 1 from then on. Such a release on the final allowed cycle takes precedence over cut-off.
- R4: When limitation has lasted `CUT_DLY` cycles, a cut-off begins. During the cut-off `gate_off_o` = 1, `diag_n_o` = 0 and `ovl_n_o` = 1.
- R5: A cut-off lasts exactly `RST_DLY` cycles, after which the outputs return to the idle values of R1.
- R6: `peak_i` has no effect while `en_i` = 0, during a cut-off, or while a fault flag is set.
- R7: `uv_i` = 1 forces `diag_n_o` = 0, `gate_off_o` = 1 and `ovl_n_o` = 1 in the same cycle. It also clears limitation, cut-off and all timers.
- R8: `ot_i` = 1 forces `diag_n_o` = 0, `gate_off_o` = 1 and `ovl_n_o` = 1 in the same cycle. When it clears, the outputs go idle at once unless a cut-off is still running, in which case they go idle when the restart interval ends.
- R9: The level of `en_i` does not change `gate_off_o` or `diag_n_o` during a cut-off.
- R10: During limitation `diag_n_o` stays 1 and `gate_off_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Driver enable |
| peak_i | input | 1 | Current crossed the peak threshold |
| above_i | input | 1 | Current still above the limit level |
| uv_i | input | 1 | Undervoltage lockout flag |
| ot_i | input | 1 | Overtemperature flag |
| gate_off_o | output | 1 | Disable the power stage |
| ovl_n_o | output | 1 | Overload report, active low |
| diag_n_o | output | 1 | Diagnostic fault flag, active low |

## Verification
The hardest situation to reach is an overtemperature event that overlaps a running cut-off. The recovery point then depends on which of the two ends later. It can only be reached by holding a limitation for the full cut-off delay first. The stimulus trips a cut-off twice. In the first trip the overtemperature clears well before the restart interval expires. In the second it outlasts the interval. A third trip is aborted by a one-cycle undervoltage pulse to show that all state is cleared.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_LIMIT = 2'd1,
    ST_CUT   = 2'd2
  } seq_st_t;
endpackage

// File: rtl/dfs_timer.sv
module dfs_timer #(
  parameter int unsigned SPAN = 8,
  localparam int unsigned W = (SPAN > 1) ? $clog2(SPAN) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         run_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] TOP = W'(SPAN - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (run_i && (cnt_q != TOP))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == TOP);
endmodule

// File: rtl/dfs_ctrl.sv
module dfs_ctrl
  import dfs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en_i,
  input  logic    peak_i,
  input  logic    above_i,
  input  logic    uv_i,
  input  logic    ot_i,
  input  logic    lim_last_i,
  input  logic    cut_last_i,
  output seq_st_t st_o
);
  seq_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (uv_i) begin
      st_d = ST_RUN;
    end else begin
      unique case (st_q)
        ST_RUN:   if (en_i && peak_i && !ot_i) st_d = ST_LIMIT;
        ST_LIMIT: begin
          if (ot_i || !en_i || !above_i) st_d = ST_RUN;
          else if (lim_last_i)           st_d = ST_CUT;
        end
        ST_CUT:   if (cut_last_i) st_d = ST_RUN;
        default:  st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= ST_RUN;
    else
      st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/dfs_outs.sv
module dfs_outs
  import dfs_pkg::*;
(
  input  seq_st_t st_i,
  input  logic    report_ok_i,
  input  logic    uv_i,
  input  logic    ot_i,
  output logic    gate_off_o,
  output logic    ovl_n_o,
  output logic    diag_n_o
);
  logic fault;

  always_comb begin
    fault      = uv_i || ot_i || (st_i == ST_CUT);
    gate_off_o = fault;
    diag_n_o   = !fault;
    ovl_n_o    = !((st_i == ST_LIMIT) && report_ok_i && !uv_i && !ot_i);
  end
endmodule

// File: rtl/drv_fault_seq.sv
module drv_fault_seq
  import dfs_pkg::*;
#(
  parameter int unsigned OVL_DLY = 4,
  parameter int unsigned CUT_DLY = 40,
  parameter int unsigned RST_DLY = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic peak_i,
  input  logic above_i,
  input  logic uv_i,
  input  logic ot_i,
  output logic gate_off_o,
  output logic ovl_n_o,
  output logic diag_n_o
);
  localparam int unsigned LW = (CUT_DLY > 1) ? $clog2(CUT_DLY) : 1;
  localparam int unsigned RW = (RST_DLY > 1) ? $clog2(RST_DLY) : 1;

  seq_st_t       st;
  logic [LW-1:0] lim_cnt;
  logic [RW-1:0] cut_cnt;
  logic          lim_last, cut_last, report_ok;

  dfs_timer #(.SPAN(CUT_DLY)) u_lim_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr_i(uv_i || (st != ST_LIMIT)),
    .run_i(st == ST_LIMIT),
    .cnt_o(lim_cnt), .last_o(lim_last)
  );

  dfs_timer #(.SPAN(RST_DLY)) u_cut_tmr (
    .clk(clk), .rst_n(rst_n),
    .clr_i(uv_i || (st != ST_CUT)),
    .run_i(st == ST_CUT),
    .cnt_o(cut_cnt), .last_o(cut_last)
  );

  assign report_ok = ({1'b0, lim_cnt} >= (LW+1)'(OVL_DLY));

  dfs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .en_i(en_i), .peak_i(peak_i), .above_i(above_i),
    .uv_i(uv_i), .ot_i(ot_i),
    .lim_last_i(lim_last), .cut_last_i(cut_last),
    .st_o(st)
  );

  dfs_outs u_outs (
    .st_i(st), .report_ok_i(report_ok),
    .uv_i(uv_i), .ot_i(ot_i),
    .gate_off_o(gate_off_o), .ovl_n_o(ovl_n_o), .diag_n_o(diag_n_o)
  );
endmodule

// File: rtl/dfs_chk.sv
module dfs_chk (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic above_i,
  input logic uv_i,
  input logic ot_i,
  input logic gate_off_o,
  input logic ovl_n_o,
  input logic diag_n_o
);
  assert_uv_forces_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |-> (!diag_n_o && gate_off_o && ovl_n_o));

  assert_uv_clears_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uv_i |=> ovl_n_o);

  assert_ot_forces_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ot_i |-> (!diag_n_o && gate_off_o));

  assert_no_report_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ovl_n_o);

  assert_release_ends_report_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !above_i |=> ovl_n_o);

  assert_report_excludes_diag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl_n_o |-> (diag_n_o && !gate_off_o));

  assert_report_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovl_n_o) |-> $past(en_i));
endmodule

bind drv_fault_seq dfs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .above_i(above_i),
  .uv_i(uv_i), .ot_i(ot_i),
  .gate_off_o(gate_off_o), .ovl_n_o(ovl_n_o), .diag_n_o(diag_n_o)
);

// File: tb/drv_fault_seq_bench.sv
module drv_fault_seq_bench;
  localparam int OD = 4;
  localparam int CD = 40;
  localparam int RD = 100;

  typedef struct {
    logic  ovl_n;
    logic  diag_n;
    logic  gate;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic en, pk, ab, uv, ot;
  logic gate_off, ovl_n, diag_n;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  drv_fault_seq #(.OVL_DLY(OD), .CUT_DLY(CD), .RST_DLY(RD)) u_drv_fault_seq (
    .clk(clk), .rst_n(rst_n), .en_i(en), .peak_i(pk), .above_i(ab),
    .uv_i(uv), .ot_i(ot),
    .gate_off_o(gate_off), .ovl_n_o(ovl_n), .diag_n_o(diag_n)
  );

  // monitor: compares what the driver queued for this cycle
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (ovl_n !== e.ovl_n || diag_n !== e.diag_n || gate_off !== e.gate) begin
        n_bad++;
        $display("FAIL %s t=%0t: ovl_n/diag_n/gate actual %b%b%b expected %b%b%b",
                 e.req, $time, ovl_n, diag_n, gate_off, e.ovl_n, e.diag_n, e.gate);
      end
    end
  end

  // driver: one cycle of stimulus plus its expected outputs
  task automatic cyc(input logic i_en, i_pk, i_ab, i_uv, i_ot,
                     input logic x_ovl, x_diag, x_gate, input string req);
    exp_t e;
    @(posedge clk);
    #1;
    en = i_en; pk = i_pk; ab = i_ab; uv = i_uv; ot = i_ot;
    e.ovl_n = x_ovl; e.diag_n = x_diag; e.gate = x_gate; e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 1, 1, 0, req);
  endtask

  // cycles 0..CD of a trip: peak in cycle 0, current held above limit
  task automatic trip_to_cut();
    cyc(1, 1, 1, 0, 0, 1, 1, 0, "R2");
    for (int k = 1; k <= CD; k++) begin
      if (k <= OD) cyc(1, 0, 1, 0, 0, 1, 1, 0, "R2");
      else         cyc(1, 0, 1, 0, 0, 0, 1, 0, "R10");
    end
  endtask

  initial begin
    rst_n = 0; en = 0; pk = 0; ab = 0; uv = 0; ot = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    idle(3, "R1");

    // full trip: report delay, cut-off, restart
    trip_to_cut();
    for (int k = CD + 1; k <= CD + RD; k++) cyc(1, 0, 1, 0, 0, 1, 0, 1, "R4");
    cyc(1, 0, 1, 0, 0, 1, 1, 0, "R5");
    idle(3, "R5");

    // peak during cut-off is ignored
    trip_to_cut();
    for (int k = CD + 1; k <= CD + RD; k++) cyc(1, 1, 1, 0, 0, 1, 0, 1, "R6");
    cyc(1, 0, 0, 0, 0, 1, 1, 0, "R5");
    idle(OD + 3, "R6");

    // limitation released before cut-off
    cyc(1, 1, 1, 0, 0, 1, 1, 0, "R3");
    for (int k = 1; k <= 9; k++) cyc(1, 0, 1, 0, 0, (k <= OD) ? 1'b1 : 1'b0, 1, 0, "R3");
    cyc(1, 0, 0, 0, 0, 0, 1, 0, "R3");
    idle(CD + 5, "R3");

    // release on the final allowed cycle beats cut-off
    cyc(1, 1, 1, 0, 0, 1, 1, 0, "R3");
    for (int k = 1; k < CD; k++) cyc(1, 0, 1, 0, 0, (k <= OD) ? 1'b1 : 1'b0, 1, 0, "R3");
    cyc(1, 0, 0, 0, 0, 0, 1, 0, "R3");
    idle(5, "R3");

    // enable low: peak ignored; enable drop ends limitation
    for (int k = 0; k < 10; k++) cyc(0, 1, 1, 0, 0, 1, 1, 0, "R6");
    cyc(1, 1, 1, 0, 0, 1, 1, 0, "R6");
    for (int k = 1; k <= 4; k++) cyc(1, 0, 1, 0, 0, 1, 1, 0, "R2");
    cyc(0, 0, 1, 0, 0, 0, 1, 0, "R6");
    cyc(0, 0, 1, 0, 0, 1, 1, 0, "R6");
    idle(3, "R6");

    // overtemperature alone, peak ignored during it
    for (int k = 0; k < 5; k++) cyc(1, 1, 1, 0, 1, 1, 0, 1, "R8");
    cyc(1, 0, 1, 0, 0, 1, 1, 0, "R8");
    idle(OD + 3, "R6");

    // overtemperature inside cut-off, clears early; enable toggled
    trip_to_cut();
    cyc(1, 0, 1, 0, 0, 1, 0, 1, "R4");
    for (int k = CD + 2; k <= CD + 10; k++) cyc(0, 0, 1, 0, 1, 1, 0, 1, "R8");
    for (int k = CD + 11; k <= CD + RD; k++) cyc(0, 0, 1, 0, 0, 1, 0, 1, "R9");
    cyc(0, 0, 1, 0, 0, 1, 1, 0, "R8");
    idle(3, "R8");

    // overtemperature outlasting the restart interval
    trip_to_cut();
    cyc(1, 0, 1, 0, 0, 1, 0, 1, "R4");
    for (int k = CD + 2; k <= CD + RD + 5; k++) cyc(1, 0, 1, 0, 1, 1, 0, 1, "R8");
    cyc(1, 0, 1, 0, 0, 1, 1, 0, "R8");
    idle(3, "R8");

    // undervoltage during limitation and during cut-off
    cyc(1, 1, 1, 0, 0, 1, 1, 0, "R2");
    for (int k = 1; k <= OD + 2; k++) cyc(1, 0, 1, 0, 0, (k <= OD) ? 1'b1 : 1'b0, 1, 0, "R2");
    cyc(1, 0, 1, 1, 0, 1, 0, 1, "R7");
    cyc(1, 0, 1, 0, 0, 1, 1, 0, "R7");
    idle(CD + 3, "R7");
    trip_to_cut();
    for (int k = CD + 1; k <= CD + 4; k++) cyc(1, 0, 1, 0, 0, 1, 0, 1, "R4");
    cyc(1, 0, 1, 1, 0, 1, 0, 1, "R7");
    cyc(1, 0, 1, 0, 0, 1, 1, 0, "R7");
    idle(3, "R7");

    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule